// File: doc/BRIEF.md
# Framed Four-Bit Code Matcher

This block takes a serial bit stream, one bit per clock when a valid strobe is high. It cuts the stream into back-to-back frames of four bits that never overlap. When the last bit of a frame arrives, it states whether the frame was one of two fixed codes, 1010 and 0110. The bit received first is the leftmost digit of the code.

The block never holds the whole frame. For each code it keeps one survival flag, which stays set while every bit received so far agrees with that code. When both flags are clear, the frame is dead. The block still counts out the remaining bits of that frame so that the frame grid is kept. A position counter marks the frame grid, and it moves only on valid cycles.

Both outputs are decided in the same cycle as the fourth bit. A consumer samples them on the clock edge that accepts that bit.

Top module: `framed_code_matcher`

## Requirements
- R1: After reset, frame_done_o and match_o are low, and the next valid bit is taken as the first bit of a new frame. This holds also when reset is applied in the middle of a frame.
- R2: frame_done_o is high in exactly those cycles where bit_vld_i is high and the bit is the 4th valid bit of the current frame. It is low in all other cycles.
- R3: In a frame_done_o cycle, match_o is high when the four valid bits of the frame, first bit leftmost, form 1010.
- R4: In a frame_done_o cycle, match_o is high when the four valid bits of the frame, first bit leftmost, form 0110.
- R5: match_o is low in every cycle without frame_done_o. It is also low in frame_done_o cycles whose frame is neither code.
- R6: A cycle with bit_vld_i low does not advance the frame position and does not change the match progress. The value on bit_in_i in such a cycle has no effect.
- R7: Frames do not overlap. Bits of an earlier frame never take part in the decision for a later frame, and after every fourth valid bit a new frame begins, whatever the result.
- R8: A frame whose leading bits already rule out both codes still lasts four valid bits. The frame that follows it is judged normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| bit_vld_i | input | 1 | Strobe that marks bit_in_i as a valid stream bit |
| bit_in_i | input | 1 | Serial data bit |
| match_o | output | 1 | High with frame_done_o when the frame equals one of the codes |
| frame_done_o | output | 1 | High in the cycle that carries the fourth valid bit of a frame |

## Verification
Two events share the cycle of a frame's last valid bit: the frame completes, and the match verdict is given. In that same cycle the survival flags are also rearmed for the next frame. The bench provokes this with all sixteen frame values sent back to back, with frames that die after their first bit and are followed at once by a code, and with valid-low gaps placed just before the fourth bit. In each cycle it judges frame_done_o and match_o against a bench model that counts valid bits and keeps a shift register of the frame.

// File: rtl/fcm_pkg.sv
package fcm_pkg;
  localparam int unsigned FCM_FRAME_BITS = 4;
  localparam int unsigned FCM_NUM_CODES  = 2;
  localparam logic [FCM_NUM_CODES*FCM_FRAME_BITS-1:0] FCM_CODES = {4'b0110, 4'b1010};
endpackage

// File: rtl/fcm_bit_pos.sv
module fcm_bit_pos #(
  parameter int unsigned FRAME_BITS = fcm_pkg::FCM_FRAME_BITS,
  localparam int unsigned POS_W = (FRAME_BITS > 2) ? $clog2(FRAME_BITS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [POS_W-1:0] pos_o,
  output logic             last_o
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

  logic [POS_W-1:0] pos_q, pos_d;

  always_comb begin
    pos_d = pos_q;
    if (adv_i) begin
      if (pos_q == LAST_POS) pos_d = '0;
      else                   pos_d = pos_q + POS_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pos_q <= '0;
    else if (adv_i) pos_q <= pos_d;
  end

  assign pos_o  = pos_q;
  assign last_o = (pos_q == LAST_POS);

  // R6: idle cycles hold the frame position
  assert_pos_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(pos_q));
  // R7: a new frame starts after the last bit
  assert_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && last_o) |=> (pos_q == '0));
endmodule

// File: rtl/fcm_code_track.sv
module fcm_code_track #(
  parameter int unsigned FRAME_BITS = fcm_pkg::FCM_FRAME_BITS,
  parameter logic [FRAME_BITS-1:0] CODE = 4'b1010,
  localparam int unsigned POS_W = (FRAME_BITS > 2) ? $clog2(FRAME_BITS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             bit_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic             last_i,
  output logic             hit_o
);
  localparam logic [POS_W-1:0] TOP_POS = POS_W'(FRAME_BITS - 1);

  logic alive_q, alive_d;
  logic exp_bit, agree;

  // first received bit is the most significant code digit
  assign exp_bit = CODE[TOP_POS - pos_i];
  assign agree   = (bit_i == exp_bit);

  always_comb begin
    alive_d = alive_q;
    if (adv_i) begin
      if (last_i) alive_d = 1'b1;
      else        alive_d = alive_q & agree;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    alive_q <= 1'b1;
    else if (adv_i) alive_q <= alive_d;
  end

  assign hit_o = adv_i & last_i & alive_q & agree;

  // R8: once a code is ruled out it stays out for the frame
  assert_dead_stays_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !last_i && !alive_q) |=> !alive_q);
  // R7: every frame starts with the code still possible
  assert_rearm_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && last_i) |=> alive_q);
  // R6: idle cycles keep the progress
  assert_idle_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(alive_q));
endmodule

// File: rtl/framed_code_matcher.sv
module framed_code_matcher #(
  parameter int unsigned FRAME_BITS = fcm_pkg::FCM_FRAME_BITS,
  parameter int unsigned NUM_CODES  = fcm_pkg::FCM_NUM_CODES,
  parameter logic [NUM_CODES*FRAME_BITS-1:0] CODES = fcm_pkg::FCM_CODES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_vld_i,
  input  logic bit_in_i,
  output logic match_o,
  output logic frame_done_o
);
  localparam int unsigned POS_W = (FRAME_BITS > 2) ? $clog2(FRAME_BITS) : 1;

  logic [POS_W-1:0]     pos;
  logic                 last;
  logic [NUM_CODES-1:0] hit_v;

  fcm_bit_pos #(.FRAME_BITS(FRAME_BITS)) u_pos (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (bit_vld_i),
    .pos_o  (pos),
    .last_o (last)
  );

  for (genvar k = 0; k < NUM_CODES; k++) begin : g_code
    fcm_code_track #(
      .FRAME_BITS (FRAME_BITS),
      .CODE       (CODES[k*FRAME_BITS +: FRAME_BITS])
    ) u_track (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .adv_i  (bit_vld_i),
      .bit_i  (bit_in_i),
      .pos_i  (pos),
      .last_i (last),
      .hit_o  (hit_v[k])
    );
  end

  assign frame_done_o = bit_vld_i & last;
  assign match_o      = |hit_v;

  // R5: a verdict only appears at a frame end
  assert_match_at_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> frame_done_o);
  // R3/R4: distinct codes never both claim one frame
  assert_single_hit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_v));
  // R2: consecutive frame ends need a full frame of valid bits
  assert_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);
endmodule

// File: tb/framed_code_matcher_tb.sv
module framed_code_matcher_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic vld, din;
  logic match, done;
  int   total = 0;
  int   bad   = 0;
  int   mpos  = 0;
  logic [3:0] mframe = '0;

  always #2 clk = ~clk;

  framed_code_matcher dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .bit_vld_i    (vld),
    .bit_in_i     (din),
    .match_o      (match),
    .frame_done_o (done)
  );

  task automatic check(input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", what, act, exp);
    end
  endtask

  function automatic logic exp_match(input logic [3:0] f);
    return (f == 4'b1010) || (f == 4'b0110);
  endfunction

  task automatic step(input logic v, input logic b, input string ctx);
    logic [3:0] full;
    logic       edone, emat;
    string      mtag;
    @(negedge clk);
    vld = v; din = b;
    #1;
    full  = {mframe[2:0], b};
    edone = v && (mpos == 3);
    emat  = edone && exp_match(full);
    if (edone && full == 4'b1010)      mtag = "R3";
    else if (edone && full == 4'b0110) mtag = "R4";
    else                               mtag = "R5";
    check(done, edone, {"R2 ", ctx});
    check(match, emat, {mtag, " ", ctx});
    @(posedge clk);
    if (v) begin
      mframe = full;
      mpos   = (mpos == 3) ? 0 : mpos + 1;
    end
  endtask

  task automatic send_frame(input logic [3:0] f, input string ctx);
    for (int i = 3; i >= 0; i--) step(1'b1, f[i], ctx);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; vld = 1'b1; din = 1'b1;
    #1;
    check(done, 1'b0, "R1 reset done");
    check(match, 1'b0, "R1 reset match");
    @(negedge clk);
    rst_n = 1'b1; vld = 1'b0;
    mpos = 0; mframe = '0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; vld = 1'b0; din = 1'b0;
    do_reset();
    // R1: the first frame after reset
    send_frame(4'b1010, "R1 first frame");
    // all sixteen values, back to back
    for (int f = 0; f < 16; f++) send_frame(f[3:0], "R7 sweep");
    // R8: a frame that dies early, followed directly by a code
    send_frame(4'b1111, "R8 dead");
    send_frame(4'b0110, "R8 after dead");
    send_frame(4'b0011, "R8 dead");
    send_frame(4'b1010, "R8 after dead");
    // R6: gaps with toggling data just before the last bit
    step(1'b1, 1'b0, "R6"); step(1'b1, 1'b1, "R6"); step(1'b1, 1'b1, "R6");
    for (int g = 0; g < 5; g++) step(1'b0, g[0], "R6 gap");
    step(1'b1, 1'b0, "R6 end");
    step(1'b0, 1'b1, "R6 gap"); step(1'b1, 1'b1, "R6"); step(1'b0, 1'b0, "R6 gap");
    step(1'b1, 1'b0, "R6"); step(1'b1, 1'b1, "R6"); step(1'b0, 1'b0, "R6 gap");
    step(1'b1, 1'b0, "R6 end");
    // R7: a code that straddles a frame boundary must not match
    send_frame(4'b0001, "R7 straddle");
    send_frame(4'b0101, "R7 straddle");
    // R1: reset in the middle of a frame
    step(1'b1, 1'b1, "R1 pre"); step(1'b1, 1'b0, "R1 pre");
    do_reset();
    send_frame(4'b0110, "R1 after mid reset");
    // random traffic with gaps
    for (int n = 0; n < 4000; n++)
      step(($urandom % 4) != 0, $urandom % 2, "R3/R4 random");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule